// File: doc/BRIEF.md
# SMBus Register Slave with Alert Response

This block is a byte-wide register slave that sits on a two-wire SMBus/I2C bus. A host can store one byte with a Write_Byte transfer. It can fetch one byte with a Read_Byte transfer, which uses a repeated START between the pointer phase and the data phase. The register space holds 256 entries. One entry is an event register. Logic elsewhere on the chip sets its bits with single-cycle pulses. Reading that entry over the bus clears it.

The bus data line uses two pins. One is a plain input. The other is an open-drain pull-down request, so the bus can run through opto-isolators. The two pins may be wired together when no isolation is needed. The seven-bit device address is built from a fixed two-bit prefix and five strap inputs.

Any event sets an active-low interrupt. The host clears the interrupt in one of two ways. It can read the event register. It can also run an Alert Response query, which returns the device address and leaves the event bits untouched. During that query the slave arbitrates bit by bit against other alerting devices. If it loses, it stops driving and keeps its interrupt asserted.

Top module: `smb_alert_slave`

## Requirements
- R1: After reset `intN` is high, `sdaDrvLow` is low, the event register is zero and every storage register reads back as 0x00.
- R2: The device address is {2'b10, strapAddr}. The slave acknowledges that address for reads and for writes, and it does not acknowledge any other address except as R9 allows.
- R3: The slave pulls SDA low for the acknowledge in the ninth clock of every byte it accepts. It changes `sdaDrvLow` only while SCL is low.
- R4: Write_Byte sets the register pointer from the first byte after the address. The next byte is then stored at that pointer.
- R5: Read_Byte sends the byte at the pointer, MSB first. When the host does not acknowledge, the slave releases SDA for the rest of the transfer.
- R6: Event bits live in the register at pointer 0x3C. A one-cycle pulse on a bit of `eventSet` sets that bit and drives `intN` low at the next clock.
- R7: A bus read of pointer 0x3C returns the event bits and clears them, and `intN` goes high. An event that arrives during or after that read is kept and asserts `intN` again.
- R8: A bus write to pointer 0x3C is acknowledged but does not change the event bits.
- R9: While `intN` is low, a read to address 0x0C (first byte 0x19) is acknowledged. The slave returns {2'b10, strapAddr, 1'b0}. Once the byte has been sent, `intN` goes high and the event bits are unchanged.
- R10: While `intN` is high, address 0x0C is not acknowledged.
- R11: If another device pulls SDA low while the slave is sending a 1 in its alert response, the slave releases SDA for the rest of the transfer and `intN` stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | Bus clock as seen on the wire |
| sdaIn | input | 1 | Bus data as seen on the wire |
| sdaDrvLow | output | 1 | High requests the open-drain driver to pull SDA low |
| strapAddr | input | 5 | Low five bits of the device address |
| eventSet | input | 8 | One-cycle pulses that set event bits |
| intN | output | 1 | Active-low interrupt |

## Verification
The bench builds the block with its default parameters: 256 registers, the event register at 0x3C, a two-stage synchronizer and address prefix 2'b10. The strap inputs are tied to 0x0B. With these values, random pointers reach the whole register space. Random foreign addresses check the address filter. The bench models the bus as a wired-AND with a second open-drain source. That source lets the alert-response arbitration loss be forced, and it lets the clearing read be overlapped with a fresh event.

// File: rtl/smb_alert_pkg.sv
package smb_alert_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_RX,
    ST_RX_ACK,
    ST_TX,
    ST_TX_ACK,
    ST_SKIP
  } busState_e;

  // strobes from protocol control to the datapath
  typedef struct packed {
    logic shiftIn;   // capture one received bit
    logic bitIn;     // synchronized SDA value
    logic loadPtr;   // received byte becomes the register pointer
    logic writeReg;  // received byte is written at the pointer
    logic loadTx;    // load the byte to transmit
    logic useAra;    // current transfer is an alert response
    logic shiftTx;   // advance to next transmit bit
    logic araDone;   // alert response byte fully sent
  } dpStrobe_t;

endpackage

// File: rtl/smb_alert_ctrl.sv
module smb_alert_ctrl
  import smb_alert_pkg::*;
#(
  parameter int SYNC_LEN = 2
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      sclIn,
  input  logic      sdaIn,
  input  logic      addrHit,
  input  logic      araHit,
  input  logic      rnw,
  input  logic      txMsb,
  output dpStrobe_t strb,
  output logic      sdaDrvLow
);

  localparam int CNT_W = 4;
  localparam logic [CNT_W-1:0] BYTE_END = CNT_W'(8);

  logic [SYNC_LEN-1:0] sclPipe, sdaPipe;
  logic sclS, sdaS, sclD, sdaD;
  logic sclRise, sclFall, startDet, stopDet;

  busState_e state, stateNxt;
  logic [CNT_W-1:0] bitCnt, cntNxt;
  logic isRead, readNxt, isAra, araNxt, firstByte, firstNxt;
  logic ackDrv, ackNxt, masterAck, mAckNxt;

  // input synchronizers, idle level high
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPipe <= '1;
      sdaPipe <= '1;
      sclD    <= 1'b1;
      sdaD    <= 1'b1;
    end else begin
      sclPipe <= {sclPipe[SYNC_LEN-2:0], sclIn};
      sdaPipe <= {sdaPipe[SYNC_LEN-2:0], sdaIn};
      sclD    <= sclS;
      sdaD    <= sdaS;
    end
  end

  assign sclS     = sclPipe[SYNC_LEN-1];
  assign sdaS     = sdaPipe[SYNC_LEN-1];
  assign sclRise  = sclS & ~sclD;
  assign sclFall  = ~sclS & sclD;
  assign startDet = sclS & sclD & sdaD & ~sdaS;
  assign stopDet  = sclS & sclD & ~sdaD & sdaS;

  always_comb begin
    stateNxt    = state;
    cntNxt      = bitCnt;
    readNxt     = isRead;
    araNxt      = isAra;
    firstNxt    = firstByte;
    ackNxt      = ackDrv;
    mAckNxt     = masterAck;
    strb        = '0;
    strb.bitIn  = sdaS;
    strb.useAra = isAra;
    if (startDet) begin
      stateNxt = ST_ADDR;
      cntNxt   = '0;
      ackNxt   = 1'b0;
      araNxt   = 1'b0;
    end else if (stopDet) begin
      stateNxt = ST_IDLE;
      ackNxt   = 1'b0;
    end else begin
      case (state)
        ST_ADDR, ST_RX: begin
          if (sclRise && bitCnt < BYTE_END) begin
            strb.shiftIn = 1'b1;
            cntNxt       = bitCnt + CNT_W'(1);
          end else if (sclFall && bitCnt == BYTE_END) begin
            if (state == ST_ADDR) begin
              if (addrHit || araHit) begin
                stateNxt = ST_ADDR_ACK;
                ackNxt   = 1'b1;
                readNxt  = rnw;
                araNxt   = araHit;
              end else begin
                stateNxt = ST_SKIP;
              end
            end else begin
              stateNxt      = ST_RX_ACK;
              ackNxt        = 1'b1;
              strb.loadPtr  = firstByte;
              strb.writeReg = ~firstByte;
              firstNxt      = 1'b0;
            end
          end
        end
        ST_ADDR_ACK: begin
          if (sclFall) begin
            ackNxt = 1'b0;
            cntNxt = '0;
            if (isRead) begin
              stateNxt    = ST_TX;
              strb.loadTx = 1'b1;
            end else begin
              stateNxt = ST_RX;
              firstNxt = 1'b1;
            end
          end
        end
        ST_RX_ACK: begin
          if (sclFall) begin
            ackNxt   = 1'b0;
            cntNxt   = '0;
            stateNxt = ST_RX;
          end
        end
        ST_TX: begin
          if (sclRise && bitCnt < BYTE_END) begin
            cntNxt = bitCnt + CNT_W'(1);
            // released a 1 but the wire is low: arbitration lost
            if (isAra && txMsb && !sdaS) stateNxt = ST_SKIP;
          end else if (sclFall) begin
            if (bitCnt == BYTE_END) begin
              stateNxt     = ST_TX_ACK;
              strb.araDone = isAra;
            end else begin
              strb.shiftTx = 1'b1;
            end
          end
        end
        ST_TX_ACK: begin
          if (sclRise) begin
            mAckNxt = ~sdaS;
          end else if (sclFall) begin
            cntNxt = '0;
            if (masterAck) begin
              stateNxt    = ST_TX;
              strb.loadTx = 1'b1;
            end else begin
              stateNxt = ST_SKIP;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      bitCnt    <= '0;
      isRead    <= 1'b0;
      isAra     <= 1'b0;
      firstByte <= 1'b0;
      ackDrv    <= 1'b0;
      masterAck <= 1'b0;
    end else begin
      state     <= stateNxt;
      bitCnt    <= cntNxt;
      isRead    <= readNxt;
      isAra     <= araNxt;
      firstByte <= firstNxt;
      ackDrv    <= ackNxt;
      masterAck <= mAckNxt;
    end
  end

  assign sdaDrvLow = (state == ST_TX) ? ~txMsb : ackDrv;

endmodule

// File: rtl/smb_alert_data.sv
module smb_alert_data
  import smb_alert_pkg::*;
#(
  parameter int                REG_DEPTH = 256,
  parameter int                EVT_W     = 8,
  parameter logic [7:0]        EVT_ADDR  = 8'h3C,
  parameter int                HI_W      = 2,
  parameter logic [HI_W-1:0]   ADDR_HI   = 2'b10,
  parameter logic [6:0]        ARA_ADDR  = 7'h0C
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [6-HI_W:0]   strapAddr,
  input  logic [EVT_W-1:0]  eventSet,
  input  dpStrobe_t         strb,
  output logic              addrHit,
  output logic              araHit,
  output logic              rnw,
  output logic              txMsb,
  output logic [EVT_W-1:0]  eventVal,
  output logic              alertOn
);

  localparam int PTR_W = $clog2(REG_DEPTH);

  logic [7:0] rxByte, txShift, rdByte, evtByte, txSrc;
  logic [6:0] ownAddr;
  logic [PTR_W-1:0] ptr;
  logic [7:0] regMem [REG_DEPTH];
  logic isEvtPtr, evtClear;
  logic [EVT_W-1:0] evtNxt;

  assign ownAddr  = {ADDR_HI, strapAddr};
  assign rnw      = rxByte[0];
  assign addrHit  = (rxByte[7:1] == ownAddr);
  assign araHit   = (rxByte[7:1] == ARA_ADDR) && rxByte[0] && alertOn;
  assign isEvtPtr = (ptr == EVT_ADDR[PTR_W-1:0]);
  assign evtClear = strb.loadTx && !strb.useAra && isEvtPtr;
  assign txMsb    = txShift[7];

  always_comb begin
    evtByte = '0;
    evtByte[EVT_W-1:0] = eventVal;
  end

  assign rdByte = isEvtPtr ? evtByte : regMem[ptr];
  assign txSrc  = strb.useAra ? {ownAddr, 1'b0} : rdByte;

  // per-bit event update: new pulses win over the clearing read
  for (genvar b = 0; b < EVT_W; b++) begin : g_evt
    assign evtNxt[b] = eventSet[b] | (eventVal[b] & ~evtClear);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxByte   <= '0;
      txShift  <= '0;
      ptr      <= '0;
      eventVal <= '0;
      alertOn  <= 1'b0;
    end else begin
      if (strb.shiftIn) rxByte <= {rxByte[6:0], strb.bitIn};
      if (strb.loadPtr) ptr <= rxByte[PTR_W-1:0];
      if (strb.loadTx) txShift <= txSrc;
      else if (strb.shiftTx) txShift <= {txShift[6:0], 1'b1};
      eventVal <= evtNxt;
      alertOn  <= (|eventSet) | (alertOn & ~(evtClear | strb.araDone));
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < REG_DEPTH; i++) regMem[i] <= '0;
    end else if (strb.writeReg && !isEvtPtr) begin
      regMem[ptr] <= rxByte;
    end
  end

endmodule

// File: rtl/smb_alert_slave.sv
module smb_alert_slave
  import smb_alert_pkg::*;
#(
  parameter int              REG_DEPTH = 256,
  parameter int              EVT_W     = 8,
  parameter logic [7:0]      EVT_ADDR  = 8'h3C,
  parameter int              HI_W      = 2,
  parameter logic [HI_W-1:0] ADDR_HI   = 2'b10,
  parameter logic [6:0]      ARA_ADDR  = 7'h0C,
  parameter int              SYNC_LEN  = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sclIn,
  input  logic             sdaIn,
  output logic             sdaDrvLow,
  input  logic [6-HI_W:0]  strapAddr,
  input  logic [EVT_W-1:0] eventSet,
  output logic             intN
);

  dpStrobe_t strb;
  logic addrHit, araHit, rnw, txMsb, alertOn;
  logic [EVT_W-1:0] eventVal;

  smb_alert_ctrl #(.SYNC_LEN(SYNC_LEN)) uCtrl (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .addrHit(addrHit), .araHit(araHit), .rnw(rnw), .txMsb(txMsb),
    .strb(strb), .sdaDrvLow(sdaDrvLow)
  );

  smb_alert_data #(
    .REG_DEPTH(REG_DEPTH), .EVT_W(EVT_W), .EVT_ADDR(EVT_ADDR),
    .HI_W(HI_W), .ADDR_HI(ADDR_HI), .ARA_ADDR(ARA_ADDR)
  ) uData (
    .clk(clk), .rstN(rstN), .strapAddr(strapAddr), .eventSet(eventSet),
    .strb(strb), .addrHit(addrHit), .araHit(araHit), .rnw(rnw),
    .txMsb(txMsb), .eventVal(eventVal), .alertOn(alertOn)
  );

  assign intN = ~alertOn;

endmodule

// File: rtl/smb_alert_slave_chk.sv
module smb_alert_slave_chk
  import smb_alert_pkg::*;
#(
  parameter int EVT_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             sclIn,
  input logic             sdaDrvLow,
  input logic [EVT_W-1:0] eventSet,
  input logic [EVT_W-1:0] eventVal,
  input logic             intN,
  input dpStrobe_t        strb
);

  assert_int_on_event_R6: assert property (@(posedge clk) disable iff (!rstN)
    (|eventSet) |=> !intN);

  // R7: a pulse is never lost, even on the clearing edge
  assert_event_kept_R7: assert property (@(posedge clk) disable iff (!rstN)
    (|eventSet) |=> ((eventVal & $past(eventSet)) == $past(eventSet)));

  assert_event_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!(|eventSet) && !strb.loadTx) |=> $stable(eventVal));

  // R7 and R9: the interrupt is released only by a read load or a finished alert response
  assert_int_release_R9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(intN) |-> $past(strb.araDone || strb.loadTx));

  assert_sda_stable_R3: assert property (@(posedge clk) disable iff (!rstN)
    (sclIn && $past(sclIn)) |-> $stable(sdaDrvLow));

endmodule

bind smb_alert_slave smb_alert_slave_chk #(.EVT_W(EVT_W)) uChk (
  .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaDrvLow(sdaDrvLow),
  .eventSet(eventSet), .eventVal(eventVal), .intN(intN), .strb(strb)
);

// File: tb/smb_alert_slave_test.sv
module smb_alert_slave_test;

  localparam int H = 8;
  localparam int Q = 4;
  localparam logic [7:0] EVT = 8'h3C;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclM = 1'b1, sdaM = 1'b1, sdaOther = 1'b1;
  logic [4:0] strap = 5'h0B;
  logic [7:0] eventSet = '0;
  logic sdaDrvLow, intN;
  wire  line = sdaM & ~sdaDrvLow & sdaOther;

  int checks = 0, errors = 0;
  bit finished = 0;
  logic [7:0] model [256];

  always #4 clk = ~clk;

  smb_alert_slave uut (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(line),
    .sdaDrvLow(sdaDrvLow), .strapAddr(strap), .eventSet(eventSet), .intN(intN)
  );

  function automatic logic [6:0] ownAddr(input logic [4:0] s);
    return {2'b10, s};
  endfunction

  function automatic logic [7:0] araReply(input logic [4:0] s);
    return {2'b10, s, 1'b0};
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic busStart();
    sdaM = 1'b0; wt(H); sclM = 1'b0;
  endtask

  task automatic busRestart();
    wt(Q); sdaM = 1'b1; wt(Q); sclM = 1'b1; wt(H); sdaM = 1'b0; wt(H); sclM = 1'b0;
  endtask

  task automatic busStop();
    wt(Q); sdaM = 1'b0; wt(Q); sclM = 1'b1; wt(H); sdaM = 1'b1; wt(H);
  endtask

  task automatic bitCyc(input logic b, output logic s);
    wt(Q); sdaM = b; wt(Q); sclM = 1'b1; wt(H); s = line; sclM = 1'b0;
  endtask

  task automatic wrByte(input logic [7:0] v, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) bitCyc(v[i], s);
    bitCyc(1'b1, s);
    ack = ~s;
  endtask

  task automatic rdByte(input logic mAck, output logic [7:0] v);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      bitCyc(1'b1, s);
      v[i] = s;
    end
    bitCyc(~mAck, s);
  endtask

  task automatic writeReg(input logic [7:0] p, input logic [7:0] d, output logic ok);
    logic a0, a1, a2;
    busStart();
    wrByte({ownAddr(strap), 1'b0}, a0);
    wrByte(p, a1);
    wrByte(d, a2);
    busStop();
    ok = a0 & a1 & a2;
  endtask

  task automatic readReg(input logic [7:0] p, output logic [7:0] d, output logic ok);
    logic a0, a1, a2;
    busStart();
    wrByte({ownAddr(strap), 1'b0}, a0);
    wrByte(p, a1);
    busRestart();
    wrByte({ownAddr(strap), 1'b1}, a2);
    rdByte(1'b0, d);
    busStop();
    ok = a0 & a1 & a2;
  endtask

  task automatic probe(input logic [7:0] first, output logic ack);
    busStart();
    wrByte(first, ack);
    busStop();
  endtask

  task automatic araQuery(output logic ack, output logic [7:0] d);
    d = 8'h00;
    busStart();
    wrByte(8'h19, ack);
    if (ack) rdByte(1'b0, d);
    busStop();
  endtask

  task automatic pulseEvt(input logic [7:0] v);
    eventSet = v; wt(1); eventSet = '0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic ok, ack;
    logic [7:0] d, p;
    for (int i = 0; i < 256; i++) model[i] = 8'h00;
    void'($urandom(32'h5EED));
    wt(5);
    rstN = 1'b1;
    wt(3);

    chk("R1 intN after reset", intN, 1);
    chk("R1 sdaDrvLow after reset", sdaDrvLow, 0);
    readReg(8'h55, d, ok);
    chk("R1 unwritten register", d, 8'h00);
    chk("R2 own address acked", ok, 1);

    // R2: foreign addresses are not acknowledged
    for (int n = 0; n < 6; n++) begin
      logic [6:0] fa;
      do fa = 7'($urandom); while (fa == ownAddr(strap) || fa == 7'h0C);
      probe({fa, n[0]}, ack);
      chk("R2 foreign address nack", ack, 0);
    end

    // R4 and R5: random register traffic against a model
    for (int n = 0; n < 28; n++) begin
      do p = 8'($urandom); while (p == EVT);
      if (($urandom % 2) == 0) begin
        d = 8'($urandom);
        writeReg(p, d, ok);
        model[p] = d;
        chk("R3 ack on write bytes", ok, 1);
      end else begin
        readReg(p, d, ok);
        chk("R5 read data", d, model[p]);
        chk("R3 ack on read bytes", ok, 1);
      end
    end
    writeReg(8'hFF, 8'hA5, ok);
    readReg(8'hFF, d, ok);
    chk("R4 top pointer write/read", d, 8'hA5);
    chk("R5 released after nack", sdaDrvLow, 0);

    araQuery(ack, d);
    chk("R10 ARA nacked while idle", ack, 0);

    pulseEvt(8'h05);
    chk("R6 intN low after event", intN, 0);
    writeReg(EVT, 8'hFF, ok);
    chk("R8 write to event acked", ok, 1);
    readReg(EVT, d, ok);
    chk("R8 event unchanged by write", d, 8'h05);
    chk("R7 intN high after read", intN, 1);
    readReg(EVT, d, ok);
    chk("R7 event cleared", d, 8'h00);

    // R7: event arriving during the clearing read is kept
    pulseEvt(8'h02);
    busStart();
    wrByte({ownAddr(strap), 1'b0}, ack);
    wrByte(EVT, ack);
    busRestart();
    wrByte({ownAddr(strap), 1'b1}, ack);
    wt(5);
    pulseEvt(8'h40);
    rdByte(1'b0, d);
    busStop();
    chk("R7 snapshot of event read", d, 8'h02);
    chk("R7 new event reasserts intN", intN, 0);
    readReg(EVT, d, ok);
    chk("R7 late event retained", d, 8'h40);
    chk("R7 intN high after second read", intN, 1);

    // R9: alert response
    pulseEvt(8'h81);
    araQuery(ack, d);
    chk("R9 ARA acked", ack, 1);
    chk("R9 ARA reply", d, araReply(strap));
    chk("R9 intN released", intN, 1);
    readReg(EVT, d, ok);
    chk("R9 event bits kept", d, 8'h81);

    // R11: arbitration loss in alert response
    pulseEvt(8'h10);
    busStart();
    wrByte(8'h19, ack);
    chk("R11 ARA acked", ack, 1);
    wt(2);
    sdaOther = 1'b0;
    rdByte(1'b0, d);
    sdaOther = 1'b1;
    busStop();
    chk("R11 wire value", d, 8'h00);
    chk("R11 intN stays low", intN, 0);
    chk("R11 slave released", sdaDrvLow, 0);
    araQuery(ack, d);
    chk("R9 ARA after lost round", d, araReply(strap));
    chk("R9 intN released after retry", intN, 1);
    readReg(EVT, d, ok);
    chk("R9 event bits after ARA", d, 8'h10);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule